// File: doc/BRIEF.md
# Endpoint FIFO Space Allocator

This block hands out regions of a shared on-chip endpoint buffer. The buffer is tracked in 512-byte units by an occupancy bitmap, with one bitmap for the transmit side and one for the receive side. Each side has its own base address and unit limit. An allocation command carries the endpoint's maximum packet size, a slot count and a direction. The block rounds the packet size up to a power of two to get the segment size. It multiplies that by the slot count plus one and converts the total into whole units. It then takes the lowest free contiguous run of that many units, marks the run used and returns the byte address of the run.

A release command carries the address that an allocation returned, together with the same packet size and slot count. The release frees that region again. The release port is separate from the allocation port, so the endpoint setup logic can free one endpoint's space and claim another in the same cycle. Each allocation produces a one-cycle response two clock edges after the command. The response carries either the address or a failure flag.

Top module: `fifoAlloc`

## Requirements
- R1: After reset both bitmaps are empty and respValid, respFail and respAddr are 0. The first allocation on a side returns that side's base address.
- R2: The unit count of a request is ceil((slot+1) * seg / 512). Here seg is the smallest power of two that is not below the packet size, and a packet size of 0 counts as 1.
- R3: A successful allocation returns base + 512 * k, where k is the lowest unit index at which the whole run is free and ends at or below the side's limit.
- R4: A free gap shorter than the requested run is skipped, even if it lies below the chosen position.
- R5: When no run fits below the limit, the response has respFail = 1 and respAddr = 0, and the bitmap is left as it was.
- R6: A release clears exactly the units that the matching allocation set, and a later allocation can reuse them.
- R7: allocDir/relDir = 0 selects the transmit bitmap and 1 selects the receive bitmap. The two bitmaps are independent, and each has its own base and limit.
- R8: Every allocation command gives exactly one respValid pulse, two rising edges after the command cycle. A release gives no response.
- R9: An allocation issued in the same cycle as a release on the same side does not see the units being freed. Both updates take effect.
- R10: A release whose address is below the side's base, or whose unit index is at or above the limit, changes nothing.
- R11: Allocations issued in consecutive cycles each see the units taken by the one before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| allocReq | input | 1 | Allocation command strobe |
| allocDir | input | 1 | Allocation side: 0 transmit, 1 receive |
| allocMaxp | input | MAXP_W | Endpoint maximum packet size in bytes |
| allocSlot | input | SLOT_W | Slot count (region holds slot+1 segments) |
| relReq | input | 1 | Release command strobe |
| relDir | input | 1 | Release side: 0 transmit, 1 receive |
| relMaxp | input | MAXP_W | Packet size used by the allocation being freed |
| relSlot | input | SLOT_W | Slot count used by the allocation being freed |
| relAddr | input | ADDR_W | Address returned by the allocation being freed |
| respValid | output | 1 | One-cycle response pulse for an allocation |
| respFail | output | 1 | No fitting run was found |
| respAddr | output | ADDR_W | Byte address of the region, 0 on failure |

## Verification
A release and an allocation can reach the same bitmap in the same cycle. The bench provokes this by driving both ports together while the receive side is completely full. The allocation must then fail, because it searches the map as it stood before the release. The allocations in the next two cycles must land exactly on the two freed units, which shows that the release was applied rather than lost. Back-to-back allocations on one side are also judged on their addresses, to show that each search sees the previous commit.

// File: rtl/fifoAllocPkg.sv
package fifoAllocPkg;

  localparam int NUM_SIDES = 2;
  localparam int SIDE_TX = 0;
  localparam int SIDE_RX = 1;

  // strobes from the control to the datapath
  typedef struct packed {
    logic       capAlloc;   // capture allocation fields this cycle
    logic       capRel;     // capture release fields this cycle
    logic [1:0] doAlloc;    // one-hot per side: search and commit
    logic [1:0] doRel;      // one-hot per side: clear region
    logic       latchResp;  // register the response
  } ctrlStrobes_t;

endpackage

// File: rtl/fifoAllocCtrl.sv
module fifoAllocCtrl
  import fifoAllocPkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         allocReq,
  input  logic         allocDir,
  input  logic         relReq,
  input  logic         relDir,
  output ctrlStrobes_t st,
  output logic         respValid
);

  logic allocPend;
  logic allocPendDir;
  logic relPend;
  logic relPendDir;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      allocPend    <= 1'b0;
      allocPendDir <= 1'b0;
      relPend      <= 1'b0;
      relPendDir   <= 1'b0;
      respValid    <= 1'b0;
    end else begin
      allocPend    <= allocReq;
      allocPendDir <= allocDir;
      relPend      <= relReq;
      relPendDir   <= relDir;
      respValid    <= allocPend;
    end
  end

  always_comb begin
    st           = '0;
    st.capAlloc  = allocReq;
    st.capRel    = relReq;
    st.latchResp = allocPend;
    if (allocPend) st.doAlloc[allocPendDir] = 1'b1;
    if (relPend)   st.doRel[relPendDir]     = 1'b1;
  end

endmodule

// File: rtl/fifoAllocBank.sv
module fifoAllocBank #(
  parameter int                NUM_UNITS = 128,
  parameter int                UCNT_W    = 5,
  parameter int                ADDR_W    = 32,
  parameter int                UNIT_LOG2 = 9,
  parameter logic [ADDR_W-1:0] BASE      = '0,
  parameter int                LIMIT     = 128
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              doAlloc,
  input  logic [UCNT_W-1:0] allocUnits,
  input  logic              doRel,
  input  logic [UCNT_W-1:0] relUnits,
  input  logic [ADDR_W-1:0] relAddr,
  output logic              found,
  output logic [ADDR_W-1:0] foundAddr
);

  localparam int IDX_W = $clog2(NUM_UNITS);

  logic [NUM_UNITS-1:0] usedMap;
  logic [NUM_UNITS-1:0] limMask;
  logic [NUM_UNITS-1:0] allocRun;
  logic [NUM_UNITS-1:0] relRun;
  logic [NUM_UNITS-1:0] setMask;
  logic [NUM_UNITS-1:0] clrMask;
  logic [IDX_W-1:0]     hitIdx;
  logic [ADDR_W-1:0]    relDiff;
  logic [ADDR_W-1:0]    relUnitIdx;
  logic                 relOk;

  function automatic logic [NUM_UNITS-1:0] runOf(input logic [UCNT_W-1:0] n);
    logic [NUM_UNITS-1:0] m;
    m = '0;
    for (int i = 0; i < NUM_UNITS; i++)
      if (i < int'(n)) m[i] = 1'b1;
    return m;
  endfunction

  always_comb begin
    for (int i = 0; i < NUM_UNITS; i++) limMask[i] = (i < LIMIT);
  end

  assign allocRun = runOf(allocUnits);
  assign relRun   = runOf(relUnits);

  // first fit: scan downward so the lowest fitting index wins
  always_comb begin
    found  = 1'b0;
    hitIdx = '0;
    for (int i = NUM_UNITS - 1; i >= 0; i--) begin
      if (((i + int'(allocUnits)) <= LIMIT) && ((usedMap & (allocRun << i)) == '0)) begin
        found  = 1'b1;
        hitIdx = IDX_W'(i);
      end
    end
  end

  assign foundAddr = BASE + (ADDR_W'(hitIdx) << UNIT_LOG2);

  // release decode
  assign relDiff    = relAddr - BASE;
  assign relUnitIdx = relDiff >> UNIT_LOG2;
  assign relOk      = (relAddr >= BASE) && (relUnitIdx < ADDR_W'(LIMIT));

  assign setMask = (doAlloc && found) ? (allocRun << hitIdx) : '0;
  assign clrMask = (doRel && relOk) ? ((relRun << relUnitIdx[IDX_W-1:0]) & limMask) : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) usedMap <= '0;
    else       usedMap <= (usedMap & ~clrMask) | setMask;
  end

endmodule

// File: rtl/fifoAllocDp.sv
module fifoAllocDp
  import fifoAllocPkg::*;
#(
  parameter int                ADDR_W    = 32,
  parameter int                UNIT_LOG2 = 9,
  parameter int                NUM_UNITS = 128,
  parameter int                MAXP_W    = 11,
  parameter int                SLOT_W    = 2,
  parameter logic [ADDR_W-1:0] BASE_TX   = 32'h0000_0000,
  parameter int                LIMIT_TX  = 128,
  parameter logic [ADDR_W-1:0] BASE_RX   = 32'h0002_0000,
  parameter int                LIMIT_RX  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      st,
  input  logic [MAXP_W-1:0] allocMaxp,
  input  logic [SLOT_W-1:0] allocSlot,
  input  logic [MAXP_W-1:0] relMaxp,
  input  logic [SLOT_W-1:0] relSlot,
  input  logic [ADDR_W-1:0] relAddr,
  output logic              respFail,
  output logic [ADDR_W-1:0] respAddr
);

  localparam int UNIT_BYTES = 1 << UNIT_LOG2;
  localparam int SEG_W      = MAXP_W + 1;
  localparam int TOT_W      = SEG_W + SLOT_W;
  localparam int MAX_UNITS  = ((2 ** SLOT_W) * (2 ** MAXP_W) + UNIT_BYTES - 1) / UNIT_BYTES;
  localparam int UCNT_W     = $clog2(MAX_UNITS + 1);

  logic [MAXP_W-1:0] aMaxp;
  logic [SLOT_W-1:0] aSlot;
  logic [MAXP_W-1:0] rMaxp;
  logic [SLOT_W-1:0] rSlot;
  logic [ADDR_W-1:0] rAddr;
  logic [UCNT_W-1:0] aUnits;
  logic [UCNT_W-1:0] rUnits;
  logic [NUM_SIDES-1:0] bankHit;
  logic [ADDR_W-1:0]    bankAddr [NUM_SIDES];
  logic                 selSide;

  function automatic logic [UCNT_W-1:0] unitsOf(input logic [MAXP_W-1:0] mp,
                                                 input logic [SLOT_W-1:0] sl);
    logic [SEG_W-1:0]  seg;
    logic [MAXP_W-1:0] m1;
    logic [TOT_W-1:0]  tot;
    seg = SEG_W'(1);
    m1  = (mp == '0) ? '0 : mp - MAXP_W'(1);
    for (int b = 0; b < MAXP_W; b++)
      if (m1[b]) seg = SEG_W'(1) << (b + 1);
    tot = TOT_W'(seg) * (TOT_W'(sl) + TOT_W'(1));
    return UCNT_W'((tot + TOT_W'(UNIT_BYTES - 1)) >> UNIT_LOG2);
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aMaxp <= '0;
      aSlot <= '0;
      rMaxp <= '0;
      rSlot <= '0;
      rAddr <= '0;
    end else begin
      if (st.capAlloc) begin
        aMaxp <= allocMaxp;
        aSlot <= allocSlot;
      end
      if (st.capRel) begin
        rMaxp <= relMaxp;
        rSlot <= relSlot;
        rAddr <= relAddr;
      end
    end
  end

  assign aUnits = unitsOf(aMaxp, aSlot);
  assign rUnits = unitsOf(rMaxp, rSlot);

  for (genvar g = 0; g < NUM_SIDES; g++) begin : gSide
    localparam logic [ADDR_W-1:0] SIDE_BASE  = (g == SIDE_TX) ? BASE_TX : BASE_RX;
    localparam int                SIDE_LIMIT = (g == SIDE_TX) ? LIMIT_TX : LIMIT_RX;
    fifoAllocBank #(
      .NUM_UNITS (NUM_UNITS),
      .UCNT_W    (UCNT_W),
      .ADDR_W    (ADDR_W),
      .UNIT_LOG2 (UNIT_LOG2),
      .BASE      (SIDE_BASE),
      .LIMIT     (SIDE_LIMIT)
    ) uBank (
      .clk        (clk),
      .rstN       (rstN),
      .doAlloc    (st.doAlloc[g]),
      .allocUnits (aUnits),
      .doRel      (st.doRel[g]),
      .relUnits   (rUnits),
      .relAddr    (rAddr),
      .found      (bankHit[g]),
      .foundAddr  (bankAddr[g])
    );
  end

  assign selSide = st.doAlloc[SIDE_RX];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      respFail <= 1'b0;
      respAddr <= '0;
    end else if (st.latchResp) begin
      respFail <= !bankHit[selSide];
      respAddr <= bankHit[selSide] ? bankAddr[selSide] : '0;
    end
  end

endmodule

// File: rtl/fifoAlloc.sv
module fifoAlloc
  import fifoAllocPkg::*;
#(
  parameter int                ADDR_W    = 32,
  parameter int                UNIT_LOG2 = 9,
  parameter int                NUM_UNITS = 128,
  parameter int                MAXP_W    = 11,
  parameter int                SLOT_W    = 2,
  parameter logic [ADDR_W-1:0] BASE_TX   = 32'h0000_0000,
  parameter int                LIMIT_TX  = 128,
  parameter logic [ADDR_W-1:0] BASE_RX   = 32'h0002_0000,
  parameter int                LIMIT_RX  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              allocReq,
  input  logic              allocDir,
  input  logic [MAXP_W-1:0] allocMaxp,
  input  logic [SLOT_W-1:0] allocSlot,
  input  logic              relReq,
  input  logic              relDir,
  input  logic [MAXP_W-1:0] relMaxp,
  input  logic [SLOT_W-1:0] relSlot,
  input  logic [ADDR_W-1:0] relAddr,
  output logic              respValid,
  output logic              respFail,
  output logic [ADDR_W-1:0] respAddr
);

  ctrlStrobes_t st;

  fifoAllocCtrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .allocReq  (allocReq),
    .allocDir  (allocDir),
    .relReq    (relReq),
    .relDir    (relDir),
    .st        (st),
    .respValid (respValid)
  );

  fifoAllocDp #(
    .ADDR_W    (ADDR_W),
    .UNIT_LOG2 (UNIT_LOG2),
    .NUM_UNITS (NUM_UNITS),
    .MAXP_W    (MAXP_W),
    .SLOT_W    (SLOT_W),
    .BASE_TX   (BASE_TX),
    .LIMIT_TX  (LIMIT_TX),
    .BASE_RX   (BASE_RX),
    .LIMIT_RX  (LIMIT_RX)
  ) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .st        (st),
    .allocMaxp (allocMaxp),
    .allocSlot (allocSlot),
    .relMaxp   (relMaxp),
    .relSlot   (relSlot),
    .relAddr   (relAddr),
    .respFail  (respFail),
    .respAddr  (respAddr)
  );

endmodule

// File: rtl/fifoAllocChk.sv
module fifoAllocChk #(
  parameter int                ADDR_W    = 32,
  parameter int                UNIT_LOG2 = 9,
  parameter logic [ADDR_W-1:0] BASE_TX   = '0,
  parameter int                LIMIT_TX  = 128,
  parameter logic [ADDR_W-1:0] BASE_RX   = '0,
  parameter int                LIMIT_RX  = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              allocReq,
  input logic              allocDir,
  input logic              respValid,
  input logic              respFail,
  input logic [ADDR_W-1:0] respAddr
);

  localparam logic [ADDR_W-1:0] TX_END = BASE_TX + (ADDR_W'(LIMIT_TX) << UNIT_LOG2);
  localparam logic [ADDR_W-1:0] RX_END = BASE_RX + (ADDR_W'(LIMIT_RX) << UNIT_LOG2);

  assert_resp_follows_R8: assert property (@(posedge clk) disable iff (!rstN)
    allocReq |-> ##2 respValid);

  assert_no_orphan_resp_R8: assert property (@(posedge clk) disable iff (!rstN)
    respValid |-> $past(allocReq, 2));

  assert_fail_zero_addr_R5: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && respFail) |-> (respAddr == '0));

  assert_unit_aligned_R3: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && !respFail) |-> (respAddr[UNIT_LOG2-1:0] == '0));

  assert_tx_window_R7: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && !respFail && !$past(allocDir, 2)) |-> (respAddr >= BASE_TX && respAddr < TX_END));

  assert_rx_window_R7: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && !respFail && $past(allocDir, 2)) |-> (respAddr >= BASE_RX && respAddr < RX_END));

endmodule

bind fifoAlloc fifoAllocChk #(
  .ADDR_W    (ADDR_W),
  .UNIT_LOG2 (UNIT_LOG2),
  .BASE_TX   (BASE_TX),
  .LIMIT_TX  (LIMIT_TX),
  .BASE_RX   (BASE_RX),
  .LIMIT_RX  (LIMIT_RX)
) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .allocReq  (allocReq),
  .allocDir  (allocDir),
  .respValid (respValid),
  .respFail  (respFail),
  .respAddr  (respAddr)
);

// File: tb/sim_fifoAlloc.sv
`timescale 1ns/1ps
module sim_fifoAlloc;

  logic        clk = 1'b0;
  logic        rstN;
  logic        allocReq, allocDir, relReq, relDir;
  logic [10:0] allocMaxp, relMaxp;
  logic [1:0]  allocSlot, relSlot;
  logic [31:0] relAddr;
  logic        respValid, respFail;
  logic [31:0] respAddr;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    logic        fail;
    logic [31:0] addr;
    string       tag;
  } expItem_t;
  expItem_t expQ[$];

  always #4 clk = ~clk;

  fifoAlloc u0 (
    .clk(clk), .rstN(rstN),
    .allocReq(allocReq), .allocDir(allocDir), .allocMaxp(allocMaxp), .allocSlot(allocSlot),
    .relReq(relReq), .relDir(relDir), .relMaxp(relMaxp), .relSlot(relSlot), .relAddr(relAddr),
    .respValid(respValid), .respFail(respFail), .respAddr(respAddr)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic setAlloc(input logic d, input int mp, input int sl,
                          input logic ef, input logic [31:0] ea, input string tag);
    expItem_t it;
    allocReq  = 1'b1;
    allocDir  = d;
    allocMaxp = mp[10:0];
    allocSlot = sl[1:0];
    it.fail = ef; it.addr = ea; it.tag = tag;
    expQ.push_back(it);
  endtask

  task automatic setRel(input logic d, input int mp, input int sl, input logic [31:0] a);
    relReq  = 1'b1;
    relDir  = d;
    relMaxp = mp[10:0];
    relSlot = sl[1:0];
    relAddr = a;
  endtask

  task automatic step();
    @(negedge clk);
    allocReq = 1'b0;
    relReq   = 1'b0;
  endtask

  // monitor: compare each response with the head of the scoreboard
  always @(negedge clk) begin
    if (rstN === 1'b1 && respValid === 1'b1) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R8 response without allocation", respAddr, 32'h0);
      end else begin
        expItem_t it;
        it = expQ.pop_front();
        check(respFail === it.fail, {it.tag, " fail flag"}, {31'h0, respFail}, {31'h0, it.fail});
        check(respAddr === it.addr, {it.tag, " address"}, respAddr, it.addr);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0;
    allocReq = 0; allocDir = 0; allocMaxp = '0; allocSlot = '0;
    relReq = 0; relDir = 0; relMaxp = '0; relSlot = '0; relAddr = '0;
    repeat (3) @(negedge clk);
    check(respValid === 1'b0, "R1 reset respValid", {31'h0, respValid}, 32'h0);
    check(respFail === 1'b0, "R1 reset respFail", {31'h0, respFail}, 32'h0);
    check(respAddr === 32'h0, "R1 reset respAddr", respAddr, 32'h0);
    rstN = 1'b1;
    @(negedge clk);

    // transmit side, base 0
    setAlloc(0, 512, 1, 0, 32'h0000, "R1 R2 tx first 2 units");  step();
    setAlloc(0, 100, 0, 0, 32'h0400, "R2 tx 128B seg 1 unit");   step();
    setAlloc(0, 1024, 2, 0, 32'h0600, "R2 R3 tx 6 units");       step();
    setAlloc(0, 513, 0, 0, 32'h1200, "R2 tx 513 rounds to 1024"); step();
    setAlloc(0, 0, 3, 0, 32'h1600, "R2 tx zero maxp 1 unit");    step();
    setRel(0, 100, 0, 32'h0400); step();
    setAlloc(0, 64, 0, 0, 32'h0400, "R6 tx reuse freed unit");   step();
    setRel(0, 1024, 2, 32'h0600); step();
    setAlloc(0, 1024, 3, 0, 32'h1800, "R4 tx skip 6-unit gap");  step();
    setAlloc(0, 2047, 1, 0, 32'h2800, "R2 R4 tx 2047 to 2048");  step();
    setAlloc(0, 512, 2, 0, 32'h0600, "R3 R6 tx lowest gap");     step();
    setAlloc(0, 512, 0, 0, 32'h0C00, "R11 back-to-back first");  step();
    setAlloc(0, 512, 0, 0, 32'h0E00, "R11 back-to-back second"); step();

    // receive side, base 0x20000, limit 16 units
    setAlloc(1, 2047, 3, 0, 32'h2_0000, "R1 R7 rx base full");   step();
    setAlloc(1, 1, 0, 1, 32'h0, "R5 rx full fails");             step();
    setRel(1, 2047, 3, 32'h1_FE00); step();
    setAlloc(1, 1, 0, 1, 32'h0, "R10 release below base");       step();
    setRel(1, 2047, 3, 32'h2_2000); step();
    setAlloc(1, 1, 0, 1, 32'h0, "R10 release at limit");         step();
    setRel(1, 2047, 3, 32'h2_0000); step();
    setAlloc(1, 512, 1, 0, 32'h2_0000, "R6 rx after full release"); step();
    setAlloc(1, 2047, 3, 1, 32'h0, "R5 rx too large");           step();
    setAlloc(1, 1024, 3, 0, 32'h2_0400, "R5 map unchanged after fail"); step();
    setAlloc(1, 1024, 2, 0, 32'h2_1400, "R3 rx run ends at limit"); step();
    setAlloc(1, 1, 0, 1, 32'h0, "R5 rx limit reached");          step();

    // release and allocation in the same cycle
    setRel(1, 512, 1, 32'h2_0000);
    setAlloc(1, 1, 0, 1, 32'h0, "R9 same-cycle alloc misses release"); step();
    setAlloc(1, 1, 0, 0, 32'h2_0000, "R9 freed unit 0 next cycle"); step();
    setAlloc(1, 1, 0, 0, 32'h2_0200, "R9 freed unit 1");         step();

    setAlloc(0, 1, 0, 0, 32'h1000, "R7 tx unaffected by rx");    step();

    repeat (4) step();
    check(expQ.size() == 0, "R8 responses outstanding", expQ.size(), 32'h0);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule